// File: doc/BRIEF.md
# Serial Clock and Chip-Select Timing Generator

This block produces the serial bit clock and the chip-select envelope for a serial flash interface master. Each chip select has its own 32-bit timing word. The word holds a rate code and three counts: setup time, hold time, and the idle gap that must pass before the next assertion. The clock rate comes from a 9-bit phase accumulator that adds the rate code on every input clock. The serial clock runs at the input clock times code/512, so one half period lasts H = 256/code input clocks.

A transaction sequencer chooses a select, sets the number of bits and pulses `start` while `ready` is high. The block then runs these steps in order:

1. Assert the chosen select line.
2. Wait the setup count in serial-clock periods.
3. Produce two clock edges per bit. Each edge carries either a sample strobe or a shift strobe, according to that select's phase setting.
4. Wait the hold count.
5. Release the select and pulse `done`.
6. Hold `ready` low for the gap count.

The clock rests at that select's polarity level whenever it is not toggling. Data shifting and the FIFOs sit outside this block.

Top module: `sfc_clk_timing`

## Requirements
- R1: In the running phase the serial clock changes level every H = 256/code input clocks, where code is the rate field. The rate field is bits 31:24 of the timing word, and a legal code is a power of two from 1 to 128.
- R2: A rate code that is zero or not a power of two behaves exactly like code 1 (H = 256).
- R3: Bits 23:16 of the timing word are the setup count, bits 15:8 the hold count and bits 7:0 the gap count. The word for select i is written at byte address 4*i. A write whose address has bits 1:0 nonzero, or whose word index is NUM_CS or more, changes nothing.
- R4: `cs_n` is active low. Only the line of the latched select is ever low, and at most one line is low at any time.
- R5: While idle, `sclk` rests at the polarity bit of the currently addressed select. With phase 0 the sample strobe comes with the leading edge, the edge that moves away from the rest level. With phase 1 it comes with the trailing edge.
- R6: The first clock edge follows the select assertion by (2*setup+1)*H input clocks.
- R7: The select stays low for exactly 2*(setup+bits+hold)*H input clocks. `done` pulses for one cycle in the first cycle the select is high again.
- R8: `ready` returns 2*gap*H input clocks after the select is released. A `start` pulse seen while `ready` is low is ignored.
- R9: The timing word, polarity, phase and bit count are captured when `start` is accepted. A write to the timing word during a transaction does not change that transaction, and it does apply to the next one.
- R10: After reset, `ready` is 1, every `cs_n` line is 1, `sclk` is 0 and `done` is 0.
- R11: A `start` with `dev_sel` of NUM_CS or more is ignored: `ready` stays 1 and no select line goes low.
- R12: A transaction of b bits produces exactly b sample strobes and b shift strobes. No strobe pulses in the same cycle as another strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing-word write enable |
| cfg_addr | input | ADDR_W | Byte address of the timing word |
| cfg_wdata | input | 32 | Timing word to write |
| clk_pol | input | NUM_CS | Clock rest level, one bit per select |
| clk_pha | input | NUM_CS | Clock phase, one bit per select |
| dev_sel | input | SEL_W | Select index for the next transaction |
| xfer_bits | input | BITS_W | Number of bits in the next transaction |
| start | input | 1 | Transaction request, accepted while ready is high |
| ready | output | 1 | High when a new transaction may start |
| done | output | 1 | One-cycle pulse when the select is released |
| sclk | output | 1 | Serial clock |
| shift_stb | output | 1 | Strobe for edges that launch the next bit |
| sample_stb | output | 1 | Strobe for edges that capture a bit |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Some rules must hold on every cycle, and the bound checker tests these continuously:
- At most one select line is low.
- The selects are all released whenever the block is ready or pulses `done`.
- The two strobes never pulse together.
- During a transaction, the clock moves only in a cycle that carries a strobe.
- The sample strobe lands on the leading or trailing edge as the latched phase requires.

Exact cycle counts need whole scenarios and are left to the bench. These are the half period for each rate code, the setup delay before the first edge, the total select-low time, and the gap before `ready`. The bench also covers the treatment of illegal codes, ignored writes, capture of parameters at start, and rejection of a start during the gap or for an out-of-range select.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int RATE_W = 8;
    localparam int CNT_W  = 8;
    localparam int ACC_W  = RATE_W + 1;

    // Timing word layout: the rate field occupies the top byte.
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  setup;
        logic [CNT_W-1:0]  hold;
        logic [CNT_W-1:0]  gap;
    } sel_param_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_RUN   = 3'd2,
        ST_HOLD  = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_t;

    // Power-of-two codes pass through; anything else runs at the slowest rate.
    function automatic logic [RATE_W-1:0] rate_legal(input logic [RATE_W-1:0] code);
        if (code != '0 && (code & (code - RATE_W'(1))) == '0)
            return code;
        return RATE_W'(1);
    endfunction

    // First phase at or after 'from' whose count is nonzero; idle when none is left.
    function automatic seq_state_t first_live(input logic [2:0] from,
                                              input logic s_nz,
                                              input logic b_nz,
                                              input logic h_nz,
                                              input logic g_nz);
        if (from <= 3'(ST_SETUP) && s_nz) return ST_SETUP;
        if (from <= 3'(ST_RUN)   && b_nz) return ST_RUN;
        if (from <= 3'(ST_HOLD)  && h_nz) return ST_HOLD;
        if (from <= 3'(ST_GAP)   && g_nz) return ST_GAP;
        return ST_IDLE;
    endfunction

endpackage

// File: rtl/sfc_param_bank.sv
module sfc_param_bank
    import sfc_pkg::*;
#(
    parameter int NUM_CS = 5,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [SEL_W-1:0]  rd_idx,
    output sel_param_t        rd_param
);
    localparam int IDX_W = ADDR_W - 2;

    sel_param_t words [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_word
        logic hit;
        assign hit = we && (addr[1:0] == 2'b00) && (addr[ADDR_W-1:2] == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst)
                words[i] <= '0;
            else if (hit)
                words[i] <= sel_param_t'(wdata);
        end
    end

    always_comb begin
        rd_param = '0;
        for (int i = 0; i < NUM_CS; i++)
            if (rd_idx == SEL_W'(i))
                rd_param = words[i];
    end

endmodule

// File: rtl/sfc_rate_gen.sv
module sfc_rate_gen
    import sfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [RATE_W-1:0] code,
    output logic              tick
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;

    // A half-period event occurs whenever the top accumulator bit changes.
    assign acc_next = acc_q + ACC_W'(code);
    assign tick     = acc_q[ACC_W-1] ^ acc_next[ACC_W-1];

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc_q <= '0;
        else
            acc_q <= acc_next;
    end

endmodule

// File: rtl/sfc_select_seq.sv
module sfc_select_seq
    import sfc_pkg::*;
#(
    parameter int NUM_CS = 5,
    parameter int SEL_W  = 3,
    parameter int BITS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic [BITS_W-1:0] xfer_bits,
    input  sel_param_t        sel_param,
    input  logic [NUM_CS-1:0] pol_vec,
    input  logic [NUM_CS-1:0] pha_vec,
    input  logic              tick,
    output logic              ready,
    output logic              done,
    output logic              sclk,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic [NUM_CS-1:0] cs_n,
    output logic [RATE_W-1:0] rate_code,
    output logic              acc_clear,
    output logic              act_pol,
    output logic              act_pha
);
    localparam int CW = BITS_W + 1;

    seq_state_t        state_q;
    seq_state_t        start_live;
    seq_state_t        nxt_live;
    logic [SEL_W-1:0]  sel_q;
    logic [CNT_W-1:0]  setup_q, hold_q, gap_q;
    logic [BITS_W-1:0] bits_q;
    logic [RATE_W-1:0] rate_q;
    logic              pol_q, pha_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     target;
    logic              sclk_q, shift_q, sample_q, done_q;
    logic              sel_ok, idle_pol, sel_pol, sel_pha;
    logic              cs_act, last_tick, leading;

    assign sel_ok = int'(dev_sel) < NUM_CS;

    always_comb begin
        sel_pol = 1'b0;
        sel_pha = 1'b0;
        for (int i = 0; i < NUM_CS; i++)
            if (dev_sel == SEL_W'(i)) begin
                sel_pol = pol_vec[i];
                sel_pha = pha_vec[i];
            end
    end
    assign idle_pol = sel_pol;

    assign start_live = first_live(3'(ST_SETUP), sel_param.setup != '0, xfer_bits != '0,
                                   sel_param.hold != '0, sel_param.gap != '0);
    assign nxt_live   = first_live(3'(state_q) + 3'd1, setup_q != '0, bits_q != '0,
                                   hold_q != '0, gap_q != '0);

    // Each phase lasts two half periods per counted unit.
    always_comb begin
        unique case (state_q)
            ST_SETUP: target = CW'({setup_q, 1'b0});
            ST_RUN:   target = {bits_q, 1'b0};
            ST_HOLD:  target = CW'({hold_q, 1'b0});
            ST_GAP:   target = CW'({gap_q, 1'b0});
            default:  target = '0;
        endcase
    end

    assign last_tick = (cnt_q + CW'(1)) == target;
    assign leading   = ~cnt_q[0];
    assign cs_act    = (state_q == ST_SETUP) || (state_q == ST_RUN) || (state_q == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            sel_q    <= '0;
            setup_q  <= '0;
            hold_q   <= '0;
            gap_q    <= '0;
            bits_q   <= '0;
            rate_q   <= RATE_W'(1);
            pol_q    <= 1'b0;
            pha_q    <= 1'b0;
            cnt_q    <= '0;
            sclk_q   <= 1'b0;
            shift_q  <= 1'b0;
            sample_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            shift_q  <= 1'b0;
            sample_q <= 1'b0;
            done_q   <= 1'b0;
            if (state_q == ST_IDLE) begin
                sclk_q <= idle_pol;
                if (start && sel_ok) begin
                    sel_q   <= dev_sel;
                    setup_q <= sel_param.setup;
                    hold_q  <= sel_param.hold;
                    gap_q   <= sel_param.gap;
                    bits_q  <= xfer_bits;
                    rate_q  <= rate_legal(sel_param.rate);
                    pol_q   <= sel_pol;
                    pha_q   <= sel_pha;
                    cnt_q   <= '0;
                    state_q <= start_live;
                end
            end else if (tick) begin
                if (state_q == ST_RUN) begin
                    sclk_q   <= ~sclk_q;
                    sample_q <= leading ^ pha_q;
                    shift_q  <= ~(leading ^ pha_q);
                end
                if (last_tick) begin
                    cnt_q   <= '0;
                    state_q <= nxt_live;
                    if (cs_act && (nxt_live == ST_GAP || nxt_live == ST_IDLE))
                        done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = ~(cs_act && (sel_q == SEL_W'(i)));
    end

    assign ready      = (state_q == ST_IDLE);
    assign acc_clear  = ready;
    assign done       = done_q;
    assign sclk       = sclk_q;
    assign shift_stb  = shift_q;
    assign sample_stb = sample_q;
    assign rate_code  = rate_q;
    assign act_pol    = pol_q;
    assign act_pha    = pha_q;

endmodule

// File: rtl/sfc_clk_timing.sv
module sfc_clk_timing
    import sfc_pkg::*;
#(
    parameter int NUM_CS = 5,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 8,
    parameter int BITS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [NUM_CS-1:0] clk_pol,
    input  logic [NUM_CS-1:0] clk_pha,
    input  logic [SEL_W-1:0]  dev_sel,
    input  logic [BITS_W-1:0] xfer_bits,
    input  logic              start,
    output logic              ready,
    output logic              done,
    output logic              sclk,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic [NUM_CS-1:0] cs_n
);
    sel_param_t        cur_param;
    logic [RATE_W-1:0] rate_code;
    logic              acc_clear;
    logic              tick;
    logic              act_pol;
    logic              act_pha;

    sfc_param_bank #(.NUM_CS(NUM_CS), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rd_idx   (dev_sel),
        .rd_param (cur_param)
    );

    sfc_rate_gen u_rate (
        .clk   (clk),
        .rst   (rst),
        .clear (acc_clear),
        .code  (rate_code),
        .tick  (tick)
    );

    sfc_select_seq #(.NUM_CS(NUM_CS), .SEL_W(SEL_W), .BITS_W(BITS_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dev_sel    (dev_sel),
        .xfer_bits  (xfer_bits),
        .sel_param  (cur_param),
        .pol_vec    (clk_pol),
        .pha_vec    (clk_pha),
        .tick       (tick),
        .ready      (ready),
        .done       (done),
        .sclk       (sclk),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb),
        .cs_n       (cs_n),
        .rate_code  (rate_code),
        .acc_clear  (acc_clear),
        .act_pol    (act_pol),
        .act_pha    (act_pha)
    );

endmodule

// File: rtl/sfc_clk_timing_chk.sv
module sfc_clk_timing_chk #(
    parameter int NUM_CS = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              done,
    input logic              sclk,
    input logic              shift_stb,
    input logic              sample_stb,
    input logic [NUM_CS-1:0] cs_n,
    input logic              act_pol,
    input logic              act_pha
);
    assert_one_select_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_ready_released_R8: assert property (@(posedge clk) disable iff (rst)
        ready |-> (&cs_n));

    assert_done_released_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (&cs_n));

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && shift_stb));

    assert_clock_moves_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (!ready && $past(!ready)) |-> ($stable(sclk) || sample_stb || shift_stb));

    assert_sample_leading_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && !act_pha) |-> (sclk != act_pol));

    assert_sample_trailing_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && act_pha) |-> (sclk == act_pol));

endmodule

bind sfc_clk_timing sfc_clk_timing_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .done       (done),
    .sclk       (sclk),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb),
    .cs_n       (cs_n),
    .act_pol    (act_pol),
    .act_pha    (act_pha)
);

// File: tb/sfc_clk_timing_bench.sv
module sfc_clk_timing_bench;
    localparam int NCS = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [7:0]     cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic [NCS-1:0] clk_pol = '0;
    logic [NCS-1:0] clk_pha = '0;
    logic [2:0]     dev_sel = '0;
    logic [15:0]    xfer_bits = '0;
    logic           start = 1'b0;
    logic           ready, done, sclk, shift_stb, sample_stb;
    logic [NCS-1:0] cs_n;

    int n_chk = 0;
    int n_err = 0;
    int m_rate [NCS];
    int m_s [NCS];
    int m_h [NCS];
    int m_d [NCS];

    always #2.5 clk = ~clk;

    sfc_clk_timing u_sfc_clk_timing (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .clk_pol(clk_pol), .clk_pha(clk_pha), .dev_sel(dev_sel), .xfer_bits(xfer_bits),
        .start(start), .ready(ready), .done(done), .sclk(sclk), .shift_stb(shift_stb),
        .sample_stb(sample_stb), .cs_n(cs_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int half_of(input int code);
        if (code > 0 && code < 256 && (code & (code - 1)) == 0)
            return 256 / code;
        return 256;
    endfunction

    function automatic bit addr_ok(input int a);
        return (a % 4 == 0) && (a / 4 < NCS);
    endfunction

    task automatic wr(input int a, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = w;
        if (addr_ok(a)) begin
            m_rate[a/4] = int'(w[31:24]); m_s[a/4] = int'(w[23:16]);
            m_h[a/4] = int'(w[15:8]);     m_d[a/4] = int'(w[7:0]);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xfer(input int sel, input int bits, input bit pol, input bit pha,
                        input bit poke_gap, input bit poke_cfg, input string rtag);
        int hh, s, h, d, n_act, label, cs_cnt, first_e, second_e, n_smp, n_sft, n_done;
        int bad_cs, bad_ph, rdy_label;
        logic [NCS-1:0] mask;
        clk_pol[sel] = pol; clk_pha[sel] = pha;
        dev_sel = 3'(sel); xfer_bits = 16'(bits);
        @(negedge clk); @(negedge clk);
        check(ready === 1'b1, "R8 ready before start", int'(ready), 1);
        check(sclk === pol, "R5 idle level", int'(sclk), int'(pol));
        hh = half_of(m_rate[sel]); s = m_s[sel]; h = m_h[sel]; d = m_d[sel];
        n_act = 2 * (s + bits + h);
        mask = NCS'(1) << sel;
        cs_cnt = 0; first_e = -1; second_e = -1; n_smp = 0; n_sft = 0; n_done = 0;
        bad_cs = 0; bad_ph = 0; rdy_label = -1; label = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (label < 40000) begin
            if (cs_n[sel] === 1'b0) cs_cnt++;
            if ((cs_n | mask) !== '1) bad_cs++;
            if (first_e < 0 && sclk !== pol) first_e = label;
            else if (first_e >= 0 && second_e < 0 && sclk === pol) second_e = label;
            if (sample_stb === 1'b1) begin
                n_smp++;
                if ((sclk !== pol) !== !pha) bad_ph++;
            end
            if (shift_stb === 1'b1) n_sft++;
            if (done === 1'b1) n_done++;
            if (ready === 1'b1) begin
                rdy_label = label;
                break;
            end
            if (poke_cfg && label == 1) begin
                cfg_we = 1'b1; cfg_addr = 8'(sel * 4);
                cfg_wdata = {8'd128, 8'd0, 8'd2, 8'd1};
                m_rate[sel] = 128; m_s[sel] = 0; m_h[sel] = 2; m_d[sel] = 1;
            end
            if (poke_cfg && label == 2) cfg_we = 1'b0;
            if (poke_gap && label == n_act * hh + 1) start = 1'b1;
            if (poke_gap && label == n_act * hh + 2) start = 1'b0;
            @(negedge clk);
            label++;
        end
        check(second_e - first_e == hh, {rtag, " half period"}, second_e - first_e, hh);
        check(first_e == (2 * s + 1) * hh, "R6 setup to first edge", first_e, (2 * s + 1) * hh);
        check(cs_cnt == n_act * hh, "R7 select low time", cs_cnt, n_act * hh);
        check(n_done == 1, "R7 done pulses", n_done, 1);
        check(rdy_label == (n_act + 2 * d) * hh, "R8 gap before ready", rdy_label, (n_act + 2 * d) * hh);
        check(bad_cs == 0, "R4 other selects high", bad_cs, 0);
        check(bad_ph == 0, "R5 sample edge vs phase", bad_ph, 0);
        check(n_smp == bits && n_sft == bits, "R12 strobe counts", n_smp * 1000 + n_sft, bits * 1001);
        if (poke_gap) begin
            @(negedge clk);
            check(ready === 1'b1 && (&cs_n), "R8 start in gap ignored", int'(ready), 1);
        end
    endtask

    initial begin
        for (int i = 0; i < NCS; i++) begin
            m_rate[i] = 0; m_s[i] = 0; m_h[i] = 0; m_d[i] = 0;
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(ready === 1'b1, "R10 ready", int'(ready), 1);
        check(cs_n === '1, "R10 cs_n", int'(cs_n), 31);
        check(sclk === 1'b0 && done === 1'b0, "R10 sclk/done", int'(sclk), 0);

        wr(0,  {8'd128, 8'd1, 8'd1, 8'd1});
        wr(4,  {8'd64,  8'd2, 8'd0, 8'd2});
        wr(8,  {8'd1,   8'd0, 8'd0, 8'd1});
        wr(12, {8'h30,  8'd0, 8'd0, 8'd0});
        wr(16, {8'd0,   8'd0, 8'd1, 8'd0});

        xfer(0, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        xfer(1, 3, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
        xfer(2, 2, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        xfer(3, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        xfer(4, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

        // R3 misaligned and out-of-range writes must not disturb select 0
        wr(1,  {8'd1, 8'd9, 8'd9, 8'd9});
        wr(20, {8'd1, 8'd9, 8'd9, 8'd9});
        wr(21, {8'd1, 8'd9, 8'd9, 8'd9});
        xfer(0, 2, 1'b1, 1'b1, 1'b0, 1'b0, "R3");

        // R9 write during a transfer applies only to the next one
        wr(4, {8'd32, 8'd1, 8'd1, 8'd1});
        xfer(1, 3, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        xfer(1, 2, 1'b0, 1'b1, 1'b0, 1'b0, "R9");

        // R8 start during the gap is ignored
        wr(0, {8'd64, 8'd1, 8'd1, 8'd3});
        xfer(0, 2, 1'b0, 1'b0, 1'b1, 1'b0, "R1");

        // R11 out-of-range select ignored
        @(negedge clk);
        dev_sel = 3'd6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(ready === 1'b1 && cs_n === '1, "R11 bad select ignored", int'(cs_n), 31);

        for (int k = 0; k < 25; k++) begin
            int sel, code;
            sel  = int'($urandom % NCS);
            code = 8 << ($urandom % 5);
            wr(sel * 4, {8'(code), 8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 4)});
            xfer(sel, 1 + int'($urandom % 8), 1'($urandom), 1'($urandom), 1'b0, 1'b0, "R1");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule